// File: doc/BRIEF.md
# Byte-Strobed Register Bank Completer

This block answers transfers on a two-phase peripheral bus and holds a small bank of 32-bit registers. A transfer opens with one setup cycle, in which the select line is high and the enable line low. The access phase follows, with enable high. The block decodes the word address to pick a register. On a write, it updates only the byte lanes whose strobe bits are set. On a read, it returns the register contents in the cycle in which it signals ready.

The ready output is the back-pressure path. While ready is low in the access phase, the requester must hold every request field unchanged. The transfer finishes on the rising edge at which select, enable and ready are all high, and a write takes effect on that edge. A parameter sets how many access cycles ready is held low. A value of zero gives a fixed two-cycle transfer.

A second parameter removes the strobe input from use, and every write then updates all four lanes. An address that is misaligned or beyond the last register completes with an error flag and touches no register.

Top module: `apb_regbank`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero.
- R2: Strobe bit n enables the write of data bits 8n+7 down to 8n; a lane whose strobe bit is 0 keeps its previous value (for example, 4'b0001, 4'b0011 and 4'b1100 write only the marked lanes, and 4'b1111 writes the whole word).
- R3: A write with strobe 4'b0000 completes normally, with the usual wait count and no error, and changes no byte.
- R4: When the strobe is configured absent (HAS_STRB = 0), every write updates all four lanes whatever the strobe input carries.
- R5: In the access phase, ready stays low for exactly WAIT_CYCLES cycles and then goes high. With WAIT_CYCLES = 0, a transfer takes one setup cycle and one access cycle.
- R6: Ready is high whenever enable is low.
- R7: The strobe input has no effect on a read: the full word is returned and no register changes.
- R8: Read data appears only in the completion cycle of a read; in every other cycle it is zero.
- R9: A transfer whose address has nonzero bits [1:0], or whose word index (address bits [7:2]) is not below NUM_REGS, raises the error flag in its completion cycle only. Such a write changes no register, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sel_i | input | 1 | Completer selected |
| enable_i | input | 1 | Access phase marker |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| strb_i | input | DATA_W/8 | Byte-lane write enables |
| ready_o | output | 1 | Transfer may complete this cycle |
| rdata_o | output | DATA_W | Read data |
| err_o | output | 1 | Bad-address completion flag |

## Verification
The hardest case to reach is a write that completes and still leaves some or all of the target's bytes untouched. The lanes it skipped must differ from what the bus carried, or a dropped mask would go unseen. The stimulus therefore first fills a register with a known pattern, then writes contrasting data under partial and all-zero strobes and reads the word back. Random strobes are mixed in at random addresses, including words just beyond the bank. A reference model merges lanes by rule. A second instance with no wait states and the strobe removed shares the bus and covers the two-cycle path.

// File: rtl/apb_rb_pkg.sv
package apb_rb_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } bus_phase_e;
endpackage

// File: rtl/apb_rb_wait.sv
module apb_rb_wait #(
  parameter int WAIT_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  output logic ready_o
);
  localparam int CW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

  logic [CW-1:0] cnt_q;

  assign ready_o = !access_i || (cnt_q == LIMIT);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (access_i && !ready_o) cnt_q <= cnt_q + CW'(1);
    else                           cnt_q <= '0;
  end
endmodule

// File: rtl/apb_rb_decode.sv
module apb_rb_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic [ADDR_W-1:0]                                  addr_i,
  output logic                                               hit_o,
  output logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] idx_o
);
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W:0] NREG = NUM_REGS[WORD_W:0];

  logic [WORD_W-1:0] word;

  assign word  = addr_i[ADDR_W-1:2];
  assign hit_o = (addr_i[1:0] == 2'b00) && ({1'b0, word} < NREG);
  assign idx_o = word[IDX_W-1:0];
endmodule

// File: rtl/apb_rb_store.sv
module apb_rb_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [DATA_W/apb_rb_pkg::LANE_W-1:0] lanes_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  import apb_rb_pkg::*;
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        regs_o[r] <= '0;
      end else if (we_i && (idx_i == IDX_W'(r))) begin
        for (int b = 0; b < NLANE; b++) begin
          if (lanes_i[b]) regs_o[r][b*LANE_W +: LANE_W] <= wdata_i[b*LANE_W +: LANE_W];
        end
      end
    end
  end
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 8,
  parameter int WAIT_CYCLES = 2,
  parameter bit HAS_STRB    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              enable_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] strb_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  import apb_rb_pkg::*;
  localparam int NLANE = DATA_W / LANE_W;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  bus_phase_e phase;
  logic access, done, hit, we;
  logic [IDX_W-1:0] idx;
  logic [NLANE-1:0] lanes;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  always_comb begin
    if (!sel_i)         phase = PH_IDLE;
    else if (!enable_i) phase = PH_SETUP;
    else                phase = PH_ACCESS;
  end

  assign access = (phase == PH_ACCESS);

  apb_rb_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (access),
    .ready_o  (ready_o)
  );

  apb_rb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  assign done  = access && ready_o;
  assign we    = done && write_i && hit;
  assign lanes = HAS_STRB ? strb_i : {NLANE{1'b1}};

  apb_rb_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .lanes_i (lanes),
    .regs_o  (regs)
  );

  assign rdata_o = (done && !write_i && hit) ? regs[idx] : '0;
  assign err_o   = done && !hit;
endmodule

// File: rtl/apb_rb_chk.sv
module apb_rb_chk #(
  parameter int DATA_W      = 32,
  parameter int WAIT_CYCLES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              enable_i,
  input logic              write_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o
);
  logic [15:0] low_cnt;
  logic        acc;

  assign acc = sel_i && enable_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)              low_cnt <= '0;
    else if (acc && !ready_o) low_cnt <= low_cnt + 16'd1;
    else                      low_cnt <= '0;
  end

  assert_ready_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> ready_o);

  assert_wait_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (low_cnt < 16'(WAIT_CYCLES))) |-> !ready_o);

  assert_wait_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (low_cnt == 16'(WAIT_CYCLES))) |-> ready_o);

  assert_rdata_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && ready_o && !write_i) |-> (rdata_o == '0));

  assert_err_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (acc && ready_o));
endmodule

bind apb_regbank apb_rb_chk #(.DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .enable_i (enable_i),
  .write_i  (write_i),
  .ready_o  (ready_o),
  .rdata_o  (rdata_o),
  .err_o    (err_o)
);

// File: tb/tb_apb_regbank.sv
module tb_apb_regbank;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NREG   = 8;
  localparam int WAIT_A = 3;
  localparam int WAIT_B = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a = 1'b0, sel_b = 1'b0;
  logic        enable = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic        ready_a, ready_b, err_a, err_b;
  logic [31:0] rdata_a, rdata_b;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_a [NREG];
  logic [31:0] model_b [NREG];

  always #2 clk = ~clk;

  apb_regbank #(.WAIT_CYCLES(WAIT_A), .HAS_STRB(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel_a), .enable_i(enable), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .strb_i(strb),
    .ready_o(ready_a), .rdata_o(rdata_a), .err_o(err_a));

  apb_regbank #(.WAIT_CYCLES(WAIT_B), .HAS_STRB(1'b0)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel_b), .enable_i(enable), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .strb_i(strb),
    .ready_o(ready_b), .rdata_o(rdata_b), .err_o(err_b));

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic addr_bad(logic [7:0] a);
    return (a[1:0] != 2'b00) || (a[7:2] >= 6'(NREG));
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input bit tgt, input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] rd, output logic er,
                      output int waits);
    @(negedge clk);
    if (tgt) sel_b = 1'b1; else sel_a = 1'b1;
    enable = 1'b0; write = wr; addr = a; wdata = d; strb = s;
    #1;
    check("R6 ready in setup", 32'(tgt ? ready_b : ready_a), 32'd1);
    check("R8 rdata quiet in setup", tgt ? rdata_b : rdata_a, 32'd0);
    @(negedge clk);
    enable = 1'b1;
    #1;
    waits = 0;
    while (!(tgt ? ready_b : ready_a) && waits < 64) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = tgt ? rdata_b : rdata_a;
    er = tgt ? err_b : err_a;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b0; enable = 1'b0; write = 1'b0; strb = '0;
  endtask

  task automatic wr_a(string tag, logic [7:0] a, logic [31:0] d, logic [3:0] s);
    logic [31:0] rd; logic er; int w;
    xfer(1'b0, 1'b1, a, d, s, rd, er, w);
    check({tag, " err"}, 32'(er), 32'(addr_bad(a)));
    check({tag, " wait count (R5)"}, 32'(w), 32'(WAIT_A));
    if (!addr_bad(a)) model_a[a[4:2]] = merge(model_a[a[4:2]], d, s);
  endtask

  task automatic rd_a(string tag, logic [7:0] a, logic [3:0] s);
    logic [31:0] rd; logic er; int w;
    xfer(1'b0, 1'b0, a, $urandom, s, rd, er, w);
    check({tag, " data"}, rd, addr_bad(a) ? 32'd0 : model_a[a[4:2]]);
    check({tag, " err"}, 32'(er), 32'(addr_bad(a)));
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er; int w;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) begin model_a[i] = '0; model_b[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int i = 0; i < NREG; i++) rd_a("R1 reset read", 8'(i * 4), 4'hF);

    // R2: lane masking over a known pattern
    wr_a("R2 full", 8'h04, 32'hFFFF_FFFF, 4'b1111);
    wr_a("R2 lane0", 8'h04, 32'h1122_3344, 4'b0001);
    rd_a("R2 after 0001", 8'h04, 4'h0);
    check("R2 lane0 value", model_a[1], 32'hFFFF_FF44);
    wr_a("R2 upper", 8'h04, 32'hAABB_CCDD, 4'b1100);
    rd_a("R2 after 1100", 8'h04, 4'h0);
    wr_a("R2 lower", 8'h04, 32'h0000_5566, 4'b0011);
    rd_a("R2 after 0011", 8'h04, 4'h0);
    check("R2 final value", model_a[1], 32'hAABB_5566);

    // R3: all-zero strobe completes normally and changes nothing
    wr_a("R3 zero strobe", 8'h04, 32'h0000_0000, 4'b0000);
    rd_a("R3 unchanged", 8'h04, 4'h0);

    // R7: strobe ignored on reads
    rd_a("R7 read strb=1111", 8'h04, 4'b1111);
    rd_a("R7 read again", 8'h04, 4'b0101);

    // R9: bad addresses
    wr_a("R9 seed reg0", 8'h00, 32'h5A5A_5A5A, 4'hF);
    wr_a("R9 write past end", 8'h20, 32'hDEAD_0000, 4'hF);
    rd_a("R9 reg0 not aliased", 8'h00, 4'h0);
    rd_a("R9 read past end", 8'h24, 4'h0);
    wr_a("R9 misaligned write", 8'h06, 32'h0BAD_0BAD, 4'hF);
    rd_a("R9 reg1 intact", 8'h04, 4'h0);

    // R4 and R5 on the zero-wait, strobe-less instance
    xfer(1'b1, 1'b1, 8'h08, 32'hDEAD_BEEF, 4'b0001, rd, er, w);
    check("R5 zero-wait write", 32'(w), 32'(WAIT_B));
    xfer(1'b1, 1'b1, 8'h0C, 32'hCAFE_F00D, 4'b0000, rd, er, w);
    xfer(1'b1, 1'b0, 8'h08, 32'h0, 4'h0, rd, er, w);
    check("R4 all lanes written", rd, 32'hDEAD_BEEF);
    check("R5 zero-wait read", 32'(w), 32'(WAIT_B));
    xfer(1'b1, 1'b0, 8'h0C, 32'h0, 4'h0, rd, er, w);
    check("R4 zero strobe ignored", rd, 32'hCAFE_F00D);

    // Random traffic against the model (R2, R3, R5, R7, R8, R9)
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a = 8'($urandom_range(0, NREG + 1) * 4);
      if ($urandom_range(0, 1) == 1) wr_a("R2 random write", a, $urandom, 4'($urandom));
      else                           rd_a("R8 random read", a, 4'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule